// File: doc/BRIEF.md
# Strided Queue Doorbell Decoder

This block sits behind the controller's register write path. It turns 32-bit host writes into updates of per-queue submission tail and completion head doorbells. The doorbells begin at a fixed base offset and alternate per queue pair: first the submission tail, then the completion head. The spacing between them comes from a runtime stride exponent `dstrd`, so the distance from one doorbell to the next is `4 << dstrd` bytes. The block holds the latest pointer for every doorbell and drives all of them as flat output vectors.

Every accepted doorbell write with a legal value produces one event on a valid/ready output stream. The event names the queue and the doorbell kind, and it gives the number of entries the write advanced the pointer by, modulo that queue's size. For a submission tail this is the count of newly submitted commands; for a completion head it is the count of freed completion slots. The event stage holds one entry. While an event waits with `evt_ready` low, `wr_ready` stays low, so a stalled consumer stalls the host write stream and no event is ever dropped.

A write that is illegal sets a sticky error flag and leaves every pointer unchanged. A write is illegal if its value is not below the queue size, or if it lands in the doorbell region without hitting a doorbell. Reads return zero.

Top module: `doorbell_stride_decoder`

## Requirements
- R1: After reset every stored pointer is 0, `evt_valid` is 0, `err_flag` is 0 and `wr_ready` is 1.
- R2: The submission tail of queue q sits at byte address `DB_BASE + (2q)*(4<<dstrd)` and the completion head at `DB_BASE + (2q+1)*(4<<dstrd)`, with `dstrd` taken at the write's acceptance.
- R3: A write with value below the queue size replaces the stored pointer, and the new value shows on `sq_tail`/`cq_head` (queue q at bits `[q*PTR_W +: PTR_W]`) from the edge that accepts it; pointers only change on an accepted write.
- R4: Each legal doorbell write yields exactly one event, on the cycle after acceptance, carrying `evt_qid`=q, `evt_is_cq` (0 submission tail, 1 completion head) and `evt_delta` = (new − old + size) mod size; no event appears otherwise.
- R5: While `evt_valid` is high and `evt_ready` low, the event fields hold steady and `wr_ready` is low.
- R6: A write whose 32-bit value is greater than or equal to the target queue's size sets `err_flag`, keeps the pointer and produces no event.
- R7: A write at or above `DB_BASE` that is not exactly on a doorbell (between two doorbells, or beyond the last one) sets `err_flag`, changes no pointer and produces no event.
- R8: A write below `DB_BASE` is accepted and has no effect: no pointer change, no event, no error.
- R9: A read request on `rd_valid` is answered one cycle later with `rd_ack` high and `rd_data` zero.
- R10: Once set, `err_flag` stays high until reset.
- R11: Writing the value already stored yields an event with `evt_delta` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dstrd | input | DSTRD_W | Stride exponent; doorbell spacing is 4<<dstrd bytes |
| sq_size | input | NUM_QP*SIZE_W | Submission queue sizes, queue q at [q*SIZE_W +: SIZE_W] |
| cq_size | input | NUM_QP*SIZE_W | Completion queue sizes, same packing |
| wr_valid | input | 1 | Host write request valid |
| wr_ready | output | 1 | Write accepted this cycle when high with wr_valid |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Written doorbell value |
| rd_valid | input | 1 | Read request to a doorbell address |
| rd_ack | output | 1 | Read response strobe, one cycle after request |
| rd_data | output | 32 | Read data, always zero |
| sq_tail | output | NUM_QP*PTR_W | Stored submission tails |
| cq_head | output | NUM_QP*PTR_W | Stored completion heads |
| evt_valid | output | 1 | Delta event valid |
| evt_ready | input | 1 | Delta event consumer ready |
| evt_qid | output | QID_W | Queue index of the event |
| evt_is_cq | output | 1 | 1 for completion head, 0 for submission tail |
| evt_delta | output | PTR_W | Entries added or freed, wrap-aware |
| err_flag | output | 1 | Sticky illegal-write flag |

## Verification
The bench builds the block with three queue pairs and 8-bit pointers. The submission sizes are 16, 5 and 256, and the completion sizes are 8, 200 and 3. A full 256-entry queue therefore reaches the top of the pointer range, and odd sizes give wraps that are not powers of two. With three pairs the address decoder has two unused index codes past the last doorbell, which the beyond-the-end error case exercises. Writes are issued with stride exponents 0, 1 and 3, so the same queue is found at different addresses. The event consumer drops ready in a repeating pattern and also in a long stall, which covers back-pressure on the write side.

// File: rtl/db_pkg.sv
package db_pkg;
  localparam int DB_WORD_W = 32;   // host doorbell write width
  localparam int DB_MIN_SHIFT = 2; // doorbell spacing is 1 << (2 + dstrd)

  typedef enum logic {
    DB_SQ_TAIL = 1'b0,
    DB_CQ_HEAD = 1'b1
  } db_kind_e;
endpackage

// File: rtl/db_addr_decode.sv
module db_addr_decode #(
  parameter int ADDR_W = 32,
  parameter int DSTRD_W = 4,
  parameter int NUM_QP = 4,
  parameter logic [ADDR_W-1:0] DB_BASE = 'h1000,
  localparam int NUM_DB = 2 * NUM_QP,
  localparam int DB_W = $clog2(NUM_DB)
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DSTRD_W-1:0] dstrd,
  output logic               in_region,
  output logic               hit,
  output logic [DB_W-1:0]    db_idx
);
  import db_pkg::*;

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] word_idx;
  logic [ADDR_W-1:0] low_mask;
  int unsigned       shift;
  logic              aligned;
  logic              in_range;

  always_comb begin
    shift     = 32'(dstrd) + DB_MIN_SHIFT;
    offset    = addr - DB_BASE;
    word_idx  = offset >> shift;
    low_mask  = ~({ADDR_W{1'b1}} << shift);
    aligned   = (offset & low_mask) == '0;
    in_range  = word_idx < ADDR_W'(NUM_DB);
    in_region = addr >= DB_BASE;
    hit       = in_region && aligned && in_range;
    db_idx    = word_idx[DB_W-1:0];
  end
endmodule

// File: rtl/db_ptr_slot.sv
module db_ptr_slot #(
  parameter int PTR_W = 16,
  localparam int SIZE_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_val,
  input  logic [SIZE_W-1:0] size,
  output logic [PTR_W-1:0]  ptr,
  output logic              bad,
  output logic [PTR_W-1:0]  delta
);
  logic [PTR_W-1:0] nv;

  assign nv  = wr_val[PTR_W-1:0];
  assign bad = wr_val >= 32'(size);

  // distance travelled forward from the stored pointer, modulo size
  always_comb begin
    if (nv >= ptr)
      delta = nv - ptr;
    else
      delta = PTR_W'(SIZE_W'(nv) + size - SIZE_W'(ptr));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr <= '0;
    else if (wr_en && !bad)
      ptr <= nv;
  end
endmodule

// File: rtl/db_evt_stage.sv
module db_evt_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid)
        out_data <= in_data;
    end
  end
endmodule

// File: rtl/doorbell_stride_decoder.sv
module doorbell_stride_decoder #(
  parameter int NUM_QP = 4,          // at least 2
  parameter int PTR_W = 16,
  parameter int ADDR_W = 32,
  parameter int DSTRD_W = 4,
  parameter logic [ADDR_W-1:0] DB_BASE = 'h1000,
  localparam int SIZE_W = PTR_W + 1,
  localparam int NUM_DB = 2 * NUM_QP,
  localparam int DB_W = $clog2(NUM_DB),
  localparam int QID_W = DB_W - 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DSTRD_W-1:0]       dstrd,
  input  logic [NUM_QP*SIZE_W-1:0] sq_size,
  input  logic [NUM_QP*SIZE_W-1:0] cq_size,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [31:0]              wr_data,
  input  logic                     rd_valid,
  output logic                     rd_ack,
  output logic [31:0]              rd_data,
  output logic [NUM_QP*PTR_W-1:0]  sq_tail,
  output logic [NUM_QP*PTR_W-1:0]  cq_head,
  output logic                     evt_valid,
  input  logic                     evt_ready,
  output logic [QID_W-1:0]         evt_qid,
  output logic                     evt_is_cq,
  output logic [PTR_W-1:0]         evt_delta,
  output logic                     err_flag
);
  import db_pkg::*;

  localparam int DB_SLOTS = 1 << DB_W;
  localparam int EVT_W = QID_W + 1 + PTR_W;

  logic             in_region;
  logic             hit;
  logic [DB_W-1:0]  db_idx;
  logic             accept;
  logic             sel_bad;
  logic             good;
  logic             err_set;
  logic [EVT_W-1:0] evt_in;
  logic [EVT_W-1:0] evt_out;
  db_kind_e         kind;

  logic             slot_bad   [DB_SLOTS];
  logic [PTR_W-1:0] slot_delta [DB_SLOTS];
  logic [PTR_W-1:0] slot_ptr   [DB_SLOTS];

  db_addr_decode #(
    .ADDR_W (ADDR_W),
    .DSTRD_W(DSTRD_W),
    .NUM_QP (NUM_QP),
    .DB_BASE(DB_BASE)
  ) u_decode (
    .addr     (wr_addr),
    .dstrd    (dstrd),
    .in_region(in_region),
    .hit      (hit),
    .db_idx   (db_idx)
  );

  assign accept  = wr_valid && wr_ready;
  assign sel_bad = slot_bad[db_idx];
  assign good    = accept && hit && !sel_bad;
  assign err_set = accept && in_region && (!hit || sel_bad);
  assign kind    = db_kind_e'(db_idx[0]);

  // one slot per doorbell: even index submission tail, odd completion head
  for (genvar q = 0; q < NUM_QP; q++) begin : g_qp
    for (genvar k = 0; k < 2; k++) begin : g_kind
      localparam int S = 2 * q + k;
      logic [SIZE_W-1:0] qsize;
      if (k == 0) begin : g_sq
        assign qsize = sq_size[q*SIZE_W +: SIZE_W];
        assign sq_tail[q*PTR_W +: PTR_W] = slot_ptr[S];
      end else begin : g_cq
        assign qsize = cq_size[q*SIZE_W +: SIZE_W];
        assign cq_head[q*PTR_W +: PTR_W] = slot_ptr[S];
      end
      db_ptr_slot #(.PTR_W(PTR_W)) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (good && (db_idx == DB_W'(S))),
        .wr_val(wr_data),
        .size  (qsize),
        .ptr   (slot_ptr[S]),
        .bad   (slot_bad[S]),
        .delta (slot_delta[S])
      );
    end
  end

  // index codes past the last doorbell never hit
  for (genvar s = NUM_DB; s < DB_SLOTS; s++) begin : g_pad
    assign slot_bad[s]   = 1'b1;
    assign slot_delta[s] = '0;
    assign slot_ptr[s]   = '0;
  end

  assign evt_in = {db_idx[DB_W-1:1], kind == DB_CQ_HEAD, slot_delta[db_idx]};

  db_evt_stage #(.W(EVT_W)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (good),
    .in_ready (wr_ready),
    .in_data  (evt_in),
    .out_valid(evt_valid),
    .out_ready(evt_ready),
    .out_data (evt_out)
  );

  assign evt_qid   = evt_out[EVT_W-1 -: QID_W];
  assign evt_is_cq = evt_out[PTR_W];
  assign evt_delta = evt_out[PTR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      rd_ack   <= 1'b0;
    end else begin
      rd_ack <= rd_valid;
      if (err_set)
        err_flag <= 1'b1;
    end
  end

  assign rd_data = '0;
endmodule

// File: rtl/doorbell_stride_decoder_chk.sv
module doorbell_stride_decoder_chk #(
  parameter int NUM_QP = 4,
  parameter int PTR_W = 16,
  parameter int QID_W = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_valid,
  input logic                    wr_ready,
  input logic                    rd_valid,
  input logic                    rd_ack,
  input logic [NUM_QP*PTR_W-1:0] sq_tail,
  input logic [NUM_QP*PTR_W-1:0] cq_head,
  input logic                    evt_valid,
  input logic                    evt_ready,
  input logic [QID_W-1:0]        evt_qid,
  input logic                    evt_is_cq,
  input logic [PTR_W-1:0]        evt_delta,
  input logic                    err_flag
);
  a_r5_evt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |=> evt_valid && $stable(evt_qid) && $stable(evt_is_cq) && $stable(evt_delta));

  a_r5_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |-> !wr_ready);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  a_r9_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_ack);

  a_r9_no_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !rd_ack);

  a_r3_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_ready) |=> $stable(sq_tail) && $stable(cq_head));

  a_r4_no_spurious_evt: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_ready) && !(evt_valid && !evt_ready) |=> !evt_valid);
endmodule

bind doorbell_stride_decoder doorbell_stride_decoder_chk #(
  .NUM_QP(NUM_QP),
  .PTR_W (PTR_W),
  .QID_W (QID_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .rd_valid (rd_valid),
  .rd_ack   (rd_ack),
  .sq_tail  (sq_tail),
  .cq_head  (cq_head),
  .evt_valid(evt_valid),
  .evt_ready(evt_ready),
  .evt_qid  (evt_qid),
  .evt_is_cq(evt_is_cq),
  .evt_delta(evt_delta),
  .err_flag (err_flag)
);

// File: tb/test_doorbell_stride_decoder.sv
`timescale 1ns/1ps
module test_doorbell_stride_decoder;
  localparam int NQ = 3;
  localparam int PW = 8;
  localparam int SW = PW + 1;
  localparam int QW = 2;
  localparam int EW = QW + 1 + PW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [3:0]      dstrd = '0;
  logic [NQ*SW-1:0] sq_size = {9'd256, 9'd5, 9'd16};
  logic [NQ*SW-1:0] cq_size = {9'd3, 9'd200, 9'd8};
  logic            wr_valid = 1'b0;
  logic            wr_ready;
  logic [31:0]     wr_addr = '0;
  logic [31:0]     wr_data = '0;
  logic            rd_valid = 1'b0;
  logic            rd_ack;
  logic [31:0]     rd_data;
  logic [NQ*PW-1:0] sq_tail, cq_head;
  logic            evt_valid;
  logic            evt_ready = 1'b0;
  logic [QW-1:0]   evt_qid;
  logic            evt_is_cq;
  logic [PW-1:0]   evt_delta;
  logic            err_flag;

  int checks = 0;
  int fails = 0;
  bit stall = 1'b0;
  int rcnt = 0;
  logic [EW-1:0] exp_q[$];
  int model_sq[NQ];
  int model_cq[NQ];

  always #2 clk = ~clk;

  doorbell_stride_decoder #(.NUM_QP(NQ), .PTR_W(PW)) i_doorbell_stride_decoder (
    .clk(clk), .rst_n(rst_n), .dstrd(dstrd), .sq_size(sq_size), .cq_size(cq_size),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ack(rd_ack), .rd_data(rd_data),
    .sq_tail(sq_tail), .cq_head(cq_head), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_qid(evt_qid), .evt_is_cq(evt_is_cq), .evt_delta(evt_delta), .err_flag(err_flag));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int qsz(input int q, input int k);
    return k ? int'(cq_size[q*SW +: SW]) : int'(sq_size[q*SW +: SW]);
  endfunction

  function automatic logic [31:0] db_addr(input int q, input int k, input int ds);
    return 32'h1000 + 32'((2 * q + k) * (4 << ds));
  endfunction

  // driver: one write; pushes the expected event when the write is legal
  task automatic host_write(input logic [31:0] a, input logic [31:0] d, input bit legal,
                            input int q, input int k);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    if (legal) begin
      int old, sz;
      sz  = qsz(q, k);
      old = k ? model_cq[q] : model_sq[q];
      exp_q.push_back({QW'(q), k[0], PW'((int'(d) - old + sz) % sz)});
      if (k) model_cq[q] = int'(d); else model_sq[q] = int'(d);
    end
    forever begin
      #1;
      if (wr_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NQ; i++) begin model_sq[i] = 0; model_cq[i] = 0; end
    exp_q.delete();
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 200) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  // monitor: pops expected events as the design hands them over
  initial forever begin
    @(negedge clk);
    evt_ready = stall ? 1'b0 : ((rcnt % 3) != 0);
    rcnt++;
    #1;
    if (rst_n && evt_valid && evt_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected event", evt_delta, 0);
      end else begin
        logic [EW-1:0] e;
        e = exp_q.pop_front();
        chk({evt_qid, evt_is_cq, evt_delta} == e, "R4 event qid/kind/delta",
            {evt_qid, evt_is_cq, evt_delta}, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    // R1 reset state
    chk(sq_tail == '0 && cq_head == '0, "R1 pointers", sq_tail, 0);
    chk(!evt_valid && !err_flag && wr_ready, "R1 flags", {evt_valid, err_flag, wr_ready}, 1);

    // R9 reads
    @(negedge clk); rd_valid = 1'b1;
    @(negedge clk); rd_valid = 1'b0;
    chk(rd_ack == 1'b1 && rd_data == '0, "R9 read ack/zero", {rd_ack, rd_data}, 33'h100000000);

    // R2 R3 R4 with stride exponent 0
    dstrd = 4'd0;
    host_write(db_addr(0, 0, 0), 5, 1, 0, 0);
    chk(sq_tail[0 +: PW] == 5, "R3 sq0 tail replaced", sq_tail[0 +: PW], 5);
    host_write(db_addr(0, 0, 0), 2, 1, 0, 0);   // wraps: delta 13
    chk(sq_tail[0 +: PW] == 2, "R4 sq0 wrap store", sq_tail[0 +: PW], 2);
    host_write(db_addr(0, 0, 0), 2, 1, 0, 0);   // R11 same value: delta 0

    // R2 stride exponent 1, odd size 200
    dstrd = 4'd1;
    host_write(db_addr(1, 1, 1), 199, 1, 1, 1);
    chk(cq_head[PW +: PW] == 199, "R2 cq1 at stride 8", cq_head[PW +: PW], 199);
    host_write(db_addr(1, 1, 1), 0, 1, 1, 1);   // delta 1

    // R2 stride exponent 3, full 256 queue
    dstrd = 4'd3;
    host_write(db_addr(2, 0, 3), 255, 1, 2, 0);
    host_write(db_addr(2, 0, 3), 10, 1, 2, 0);  // delta 11
    chk(sq_tail[2*PW +: PW] == 10, "R2 sq2 at stride 32", sq_tail[2*PW +: PW], 10);
    host_write(db_addr(2, 1, 3), 2, 1, 2, 1);
    chk(cq_head[2*PW +: PW] == 2, "R3 cq2 head", cq_head[2*PW +: PW], 2);
    drain();
    chk(exp_q.size() == 0, "R4 all events seen", exp_q.size(), 0);

    // R5 back-pressure
    stall = 1'b1;
    @(negedge clk);
    host_write(db_addr(0, 1, 3), 7, 1, 0, 1);
    #1;
    begin
      logic [EW-1:0] held;
      held = {evt_qid, evt_is_cq, evt_delta};
      chk(evt_valid && !wr_ready, "R5 stall blocks writes", {evt_valid, wr_ready}, 2);
      repeat (3) @(negedge clk);
      #1;
      chk({evt_qid, evt_is_cq, evt_delta} == held && evt_valid, "R5 event held",
          {evt_qid, evt_is_cq, evt_delta}, held);
      chk(!wr_ready, "R5 wr_ready low", wr_ready, 0);
    end
    stall = 1'b0;
    drain();
    chk(exp_q.size() == 0, "R5 stalled event delivered", exp_q.size(), 0);

    // R8 below base: no effect
    host_write(32'h0000_0FFC, 3, 0, 0, 0);
    drain();
    chk(!err_flag, "R8 no error", err_flag, 0);
    chk(sq_tail[0 +: PW] == 2 && cq_head[0 +: PW] == 7, "R8 pointers kept",
        sq_tail[0 +: PW], 2);

    // R6 value not below size (sq1 size 5)
    host_write(db_addr(1, 0, 3), 5, 0, 1, 0);
    drain();
    chk(err_flag, "R6 error set", err_flag, 1);
    chk(sq_tail[PW +: PW] == 0, "R6 pointer kept", sq_tail[PW +: PW], 0);

    // R10 sticky across a later legal write
    host_write(db_addr(1, 0, 3), 4, 1, 1, 0);
    drain();
    chk(err_flag, "R10 error sticky", err_flag, 1);
    chk(sq_tail[PW +: PW] == 4, "R10 legal write after error", sq_tail[PW +: PW], 4);

    // R7 between doorbells
    do_reset();
    dstrd = 4'd1;
    host_write(32'h1004, 1, 0, 0, 0);
    drain();
    chk(err_flag, "R7 gap error", err_flag, 1);
    chk(sq_tail == '0 && cq_head == '0, "R7 gap pointers kept", sq_tail, 0);

    // R7 beyond last doorbell (index 6 of 6)
    do_reset();
    host_write(32'h1000 + 32'(6 * 8), 1, 0, 0, 0);
    drain();
    chk(err_flag, "R7 past-end error", err_flag, 1);
    chk(exp_q.size() == 0 && !evt_valid, "R7 no event", evt_valid, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule